// File: doc/BRIEF.md
# Extended capability list walker

This engine walks the chain of capability headers held in a 4 KB configuration space. Each header is a 32-bit word in a synchronous RAM. The walk always enters the chain at byte offset 256 and follows the next pointer of each header. It stops when a header carries the requested 16-bit identifier, or when the chain ends. It then reports two offsets: the offset where the match was found, or 0 when there is none, and the offset of the entry visited just before it.

A second command links a new capability into the chain. In that case the engine looks for the last entry. It rewrites only that entry's pointer field so that it points at the new offset. It then writes the new header with a zero pointer. When the new entry is placed at offset 256 itself, the old pointer found there is carried into the new header.

Bad pointers raise an error, and so does a chain that never ends. A simple start/busy/done handshake controls the engine, and a command is taken only while the engine is idle.

Top module: `ecap_walker`

## Requirements
- R1: After reset busy_o, done_o and err_o are 0, match_off_o and prev_off_o are 0, and mem_req_o is 0.
- R2: A header word holds the identifier in bits 15:0, the version in bits 19:16 and the next byte offset in bits 31:20. A byte offset maps to word address offset/4 (offset bits 11:2). Each visited entry costs exactly one read (mem_req_o=1, mem_we_o=0), and its data is taken from mem_rdata_i on the following cycle.
- R3: The walk starts at offset 256. If the word read there is all zero, the command finishes with match_off_o=0, prev_off_o=0 and err_o=0.
- R4: A find stops at the first entry whose identifier equals cap_id_i. It reports match_off_o equal to that entry's offset and prev_off_o equal to the entry visited before it (0 for the entry at 256).
- R5: A find that reaches an entry with next pointer 0 and no hit reports match_off_o=0 and prev_off_o equal to that last entry's offset. An identifier of 0 never matches, so searching for 0 returns the tail.
- R6: A next pointer below 256 or above 4088 ends the walk with err_o=1 and match_off_o=0.
- R7: A walk that visits 960 entries without ending stops with err_o=1 after exactly 960 reads.
- R8: An append (append_i=1) at an offset other than 256 first finds the tail. It then writes the tail header with bits 31:20 set to new_off_i and bits 19:0 unchanged. After that it writes {12'h000, cap_ver_i, cap_id_i} at new_off_i. It reports match_off_o=new_off_i and prev_off_o equal to the tail offset.
- R9: An append at offset 256 writes {old next of 256, cap_ver_i, cap_id_i} at 256 and reports prev_off_o=0.
- R10: An append whose new_off_i is not 4-byte aligned, or lies outside 256..4088, ends with err_o=1 and performs no write. So does an append at an offset other than 256 into an empty list.
- R11: start_i is accepted only while busy_o=0. busy_o is high from the cycle after acceptance until done_o, and done_o is a one-cycle pulse. A start_i while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command request |
| append_i | input | 1 | 1 = append, 0 = find |
| cap_id_i | input | 16 | Identifier to find or to write |
| cap_ver_i | input | 4 | Version for the appended header |
| new_off_i | input | 12 | Byte offset of the appended entry |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last command failed |
| match_off_o | output | 12 | Offset of match or new entry, 0 if none |
| prev_off_o | output | 12 | Offset of preceding entry |
| mem_req_o | output | 1 | RAM access strobe |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | 10 | RAM word address |
| mem_wdata_o | output | 32 | RAM write data |
| mem_rdata_i | input | 32 | RAM read data, valid one cycle after a read |

## Verification
The hardest condition to reach is the step limit. A valid chain cannot hold 960 distinct entries inside the space, so the limit is never hit by a legal list. The stimulus creates the condition with a header at 256 whose pointer names 256 itself, and then counts the reads the engine issues before it gives up. Append correctness is judged from the bench's RAM model: the stimulus compares the tail and new words and counts the writes, including for rejected offsets, where the count must stay at zero.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int unsigned ID_W  = 16;
  localparam int unsigned VER_W = 4;
  localparam int unsigned PTR_W = 12;
  localparam int unsigned HDR_W = ID_W + VER_W + PTR_W;

  typedef struct packed {
    logic [PTR_W-1:0] nxt;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } ecap_hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_EVAL = 3'd2,
    ST_LINK = 3'd3,
    ST_NEW  = 3'd4
  } walk_st_e;
endpackage

// File: rtl/ecap_hdr_unpack.sv
module ecap_hdr_unpack
  import ecap_pkg::*;
(
  input  logic [HDR_W-1:0] word_i,
  input  logic [ID_W-1:0]  target_i,
  input  logic             tail_mode_i,
  output ecap_hdr_t        hdr_o,
  output logic             empty_o,
  output logic             hit_o
);
  assign hdr_o   = ecap_hdr_t'(word_i);
  assign empty_o = (word_i == '0);
  // id 0 is reserved: it never hits, so the walk runs to the tail
  assign hit_o   = !tail_mode_i && (target_i != '0) && (hdr_o.id == target_i);
endmodule

// File: rtl/ecap_range_chk.sv
module ecap_range_chk #(
  parameter int unsigned OFF_W       = 12,
  parameter int unsigned LO          = 256,
  parameter int unsigned HI          = 4088,
  parameter bit          CHECK_ALIGN = 1'b0
) (
  input  logic [OFF_W-1:0] off_i,
  output logic             ok_o
);
  localparam logic [OFF_W-1:0] LO_L = OFF_W'(LO);
  localparam logic [OFF_W-1:0] HI_L = OFF_W'(HI);

  logic in_win;
  assign in_win = (off_i >= LO_L) && (off_i <= HI_L);

  generate
    if (CHECK_ALIGN) begin : g_align
      assign ok_o = in_win && (off_i[1:0] == 2'b00);
    end else begin : g_noalign
      assign ok_o = in_win;
    end
  endgenerate
endmodule

// File: rtl/ecap_step_ctr.sv
module ecap_step_ctr #(
  parameter int unsigned MAX_STEPS = 960
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam int unsigned STEP_W = $clog2(MAX_STEPS + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(MAX_STEPS - 1);

  logic [STEP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i && !at_limit_o) cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q == LAST);
endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
  import ecap_pkg::*;
#(
  parameter int unsigned BASE_OFF  = 256,
  parameter int unsigned MAX_STEPS = 960,
  parameter int unsigned TAIL_GAP  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               append_i,
  input  logic [ID_W-1:0]    cap_id_i,
  input  logic [VER_W-1:0]   cap_ver_i,
  input  logic [PTR_W-1:0]   new_off_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [PTR_W-1:0]   match_off_o,
  output logic [PTR_W-1:0]   prev_off_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [PTR_W-3:0]   mem_addr_o,
  output logic [HDR_W-1:0]   mem_wdata_o,
  input  logic [HDR_W-1:0]   mem_rdata_i
);
  localparam int unsigned OFF_W     = PTR_W;
  localparam int unsigned CFG_BYTES = 1 << OFF_W;
  localparam int unsigned MAX_OFF   = CFG_BYTES - TAIL_GAP;
  localparam logic [OFF_W-1:0] BASE_L = OFF_W'(BASE_OFF);

  walk_st_e         st_q;
  logic [OFF_W-1:0] cur_q, prev_q, new_q;
  ecap_hdr_t        hdr_q;
  logic             app_q, base_q;
  logic [ID_W-1:0]  id_q;
  logic [VER_W-1:0] ver_q;
  logic [OFF_W-1:0] match_q, prevo_q;
  logic             err_q, done_q;

  ecap_hdr_t rd_hdr;
  logic      rd_empty, rd_hit, nxt_ok, new_ok, at_limit;
  logic      accept, in_eval;

  assign accept  = start_i && (st_q == ST_IDLE);
  assign in_eval = (st_q == ST_EVAL);

  ecap_hdr_unpack u_unpack (
    .word_i      (mem_rdata_i),
    .target_i    (id_q),
    .tail_mode_i (app_q),
    .hdr_o       (rd_hdr),
    .empty_o     (rd_empty),
    .hit_o       (rd_hit)
  );

  ecap_range_chk #(.OFF_W(OFF_W), .LO(BASE_OFF), .HI(MAX_OFF), .CHECK_ALIGN(1'b0)) u_nxt_chk (
    .off_i (rd_hdr.nxt),
    .ok_o  (nxt_ok)
  );

  ecap_range_chk #(.OFF_W(OFF_W), .LO(BASE_OFF), .HI(MAX_OFF), .CHECK_ALIGN(1'b1)) u_new_chk (
    .off_i (new_off_i),
    .ok_o  (new_ok)
  );

  ecap_step_ctr #(.MAX_STEPS(MAX_STEPS)) u_steps (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .inc_i      (in_eval),
    .at_limit_o (at_limit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      prev_q  <= '0;
      new_q   <= '0;
      hdr_q   <= '0;
      app_q   <= 1'b0;
      base_q  <= 1'b0;
      id_q    <= '0;
      ver_q   <= '0;
      match_q <= '0;
      prevo_q <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            id_q    <= cap_id_i;
            ver_q   <= cap_ver_i;
            new_q   <= new_off_i;
            app_q   <= append_i;
            base_q  <= append_i && (new_off_i == BASE_L);
            cur_q   <= BASE_L;
            prev_q  <= '0;
            match_q <= '0;
            prevo_q <= '0;
            err_q   <= 1'b0;
            if (append_i && !new_ok) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              st_q <= ST_RD;
            end
          end
        end
        ST_RD: st_q <= ST_EVAL;
        ST_EVAL: begin
          if (base_q) begin
            hdr_q <= rd_hdr;
            st_q  <= ST_NEW;
          end else if ((cur_q == BASE_L) && rd_empty) begin
            err_q  <= app_q;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (rd_hit) begin
            match_q <= cur_q;
            prevo_q <= prev_q;
            done_q  <= 1'b1;
            st_q    <= ST_IDLE;
          end else if (rd_hdr.nxt == '0) begin
            if (app_q) begin
              hdr_q <= rd_hdr;
              st_q  <= ST_LINK;
            end else begin
              prevo_q <= cur_q;
              done_q  <= 1'b1;
              st_q    <= ST_IDLE;
            end
          end else if (!nxt_ok || at_limit) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            prev_q <= cur_q;
            cur_q  <= rd_hdr.nxt;
            st_q   <= ST_RD;
          end
        end
        ST_LINK: st_q <= ST_NEW;
        ST_NEW: begin
          match_q <= new_q;
          prevo_q <= base_q ? '0 : cur_q;
          done_q  <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q[OFF_W-1:2];
      end
      ST_LINK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q[OFF_W-1:2];
        mem_wdata_o = {new_q, hdr_q.ver, hdr_q.id};
      end
      ST_NEW: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = new_q[OFF_W-1:2];
        mem_wdata_o = {(base_q ? hdr_q.nxt : {OFF_W{1'b0}}), ver_q, id_q};
      end
      default: ;
    endcase
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign match_off_o = match_q;
  assign prev_off_o  = prevo_q;
endmodule

// File: rtl/ecap_walker_chk.sv
module ecap_walker_chk #(
  parameter int unsigned BASE_OFF = 256,
  parameter int unsigned MAX_OFF  = 4088
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [11:0] match_off_o,
  input logic        mem_req_o,
  input logic [9:0]  mem_addr_o
);
  logic [11:0] byte_off;
  assign byte_off = {mem_addr_o, 2'b00};

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_IDLE_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R11
  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R11
  AST_MEM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (byte_off >= 12'(BASE_OFF)) && (byte_off <= 12'(MAX_OFF))); // R6
  AST_ERR_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (match_off_o == 12'h000)); // R6
  AST_MATCH_IN_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (match_off_o == 12'h000) || (match_off_o >= 12'(BASE_OFF))); // R4
endmodule

bind ecap_walker ecap_walker_chk #(
  .BASE_OFF (BASE_OFF),
  .MAX_OFF  ((1 << 12) - TAIL_GAP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .match_off_o (match_off_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/ecap_walker_tb.sv
module ecap_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {id, expected match, expected prev, expected reads}
  localparam logic [43:0] VEC [NVEC] = '{
    {16'h0001, 12'h100, 12'h000, 4'd1},
    {16'h000B, 12'h140, 12'h100, 4'd2},
    {16'h0010, 12'h200, 12'h140, 4'd3},
    {16'h0000, 12'h000, 12'h200, 4'd3},
    {16'h1234, 12'h000, 12'h200, 4'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, append = 1'b0;
  logic [15:0] cap_id = '0;
  logic [3:0]  cap_ver = '0;
  logic [11:0] new_off = '0;
  logic busy, done, err, mem_req, mem_we;
  logic [11:0] match_off, prev_off;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [1024];
  logic        tb_we = 1'b0;
  logic [9:0]  tb_addr = '0;
  logic [31:0] tb_data = '0;
  int rd_cnt = 0, wr_cnt = 0;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    if (mem_req) begin
      if (mem_we) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
      else begin mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
    end
  end

  ecap_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .append_i(append),
    .cap_id_i(cap_id), .cap_ver_i(cap_ver), .new_off_i(new_off),
    .busy_o(busy), .done_o(done), .err_o(err),
    .match_off_o(match_off), .prev_off_o(prev_off),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] off, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = off[11:2]; tb_data = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic build_list();
    poke(12'h100, {12'h140, 4'h1, 16'h0001});
    poke(12'h140, {12'h200, 4'h2, 16'h000B});
    poke(12'h200, {12'h000, 4'h1, 16'h0010});
  endtask

  task automatic run(input logic app, input logic [15:0] id, input logic [3:0] ver,
                     input logic [11:0] off);
    int t;
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    start = 1'b1; append = app; cap_id = id; cap_ver = ver; new_off = off;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk("R11 done seen", {31'd0, done}, 32'd1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++; n_chk++;
        $display("FAIL R11 watchdog actual %0d expected < 150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 err", {31'd0, err}, 0);
    chk("R1 match", {20'd0, match_off}, 0);
    chk("R1 prev", {20'd0, prev_off}, 0);
    chk("R1 mem_req", {31'd0, mem_req}, 0);
    rst_n = 1'b1;

    // R3 empty list
    run(1'b0, 16'h0010, 4'h0, 12'h000);
    chk("R3 match", {20'd0, match_off}, 0);
    chk("R3 prev", {20'd0, prev_off}, 0);
    chk("R3 err", {31'd0, err}, 0);

    // R4 R5 R2 vector table
    build_list();
    for (int v = 0; v < NVEC; v++) begin
      run(1'b0, VEC[v][43:28], 4'h0, 12'h000);
      chk("R4/R5 match", {20'd0, match_off}, {20'd0, VEC[v][27:16]});
      chk("R4/R5 prev", {20'd0, prev_off}, {20'd0, VEC[v][15:4]});
      chk("R2 reads", rd_cnt, {28'd0, VEC[v][3:0]});
      chk("R5 err", {31'd0, err}, 0);
    end

    // R11 busy timing and ignored start
    @(negedge clk);
    rd_cnt = 0;
    start = 1'b1; append = 1'b0; cap_id = 16'h0010;
    @(negedge clk);
    chk("R11 busy after start", {31'd0, busy}, 1);
    cap_id = 16'h0001;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk("R11 ignored start match", {20'd0, match_off}, 32'h200);
    chk("R11 ignored start reads", rd_cnt, 3);
    @(negedge clk);
    chk("R11 done pulse", {31'd0, done}, 0);
    chk("R11 idle", {31'd0, busy}, 0);

    // R8 append at tail
    run(1'b1, 16'h0025, 4'h3, 12'h300);
    chk("R8 err", {31'd0, err}, 0);
    chk("R8 match", {20'd0, match_off}, 32'h300);
    chk("R8 prev", {20'd0, prev_off}, 32'h200);
    chk("R8 writes", wr_cnt, 2);
    chk("R8 tail word", mem[12'h200 >> 2], {12'h300, 4'h1, 16'h0010});
    chk("R8 new word", mem[12'h300 >> 2], {12'h000, 4'h3, 16'h0025});
    run(1'b0, 16'h0025, 4'h0, 12'h000);
    chk("R8 find new", {20'd0, match_off}, 32'h300);
    chk("R8 find new prev", {20'd0, prev_off}, 32'h200);

    // R9 append at base keeps next
    run(1'b1, 16'h00AA, 4'h5, 12'h100);
    chk("R9 err", {31'd0, err}, 0);
    chk("R9 word", mem[12'h100 >> 2], {12'h140, 4'h5, 16'h00AA});
    chk("R9 prev", {20'd0, prev_off}, 0);
    chk("R9 match", {20'd0, match_off}, 32'h100);
    chk("R9 writes", wr_cnt, 1);

    // R10 bad append offsets
    run(1'b1, 16'h0033, 4'h1, 12'h302);
    chk("R10 misaligned err", {31'd0, err}, 1);
    chk("R10 misaligned writes", wr_cnt, 0);
    run(1'b1, 16'h0033, 4'h1, 12'hFFC);
    chk("R10 high err", {31'd0, err}, 1);
    chk("R10 high writes", wr_cnt, 0);
    run(1'b1, 16'h0033, 4'h1, 12'h0F0);
    chk("R10 low err", {31'd0, err}, 1);
    chk("R10 low writes", wr_cnt, 0);
    poke(12'h100, 32'h0);
    run(1'b1, 16'h0033, 4'h1, 12'h180);
    chk("R10 empty err", {31'd0, err}, 1);
    chk("R10 empty writes", wr_cnt, 0);
    run(1'b1, 16'h0044, 4'h2, 12'h100);
    chk("R9 empty base err", {31'd0, err}, 0);
    chk("R9 empty base word", mem[12'h100 >> 2], {12'h000, 4'h2, 16'h0044});

    // R6 pointer range
    poke(12'h100, {12'h0F0, 4'h1, 16'h0001});
    run(1'b0, 16'h0010, 4'h0, 12'h000);
    chk("R6 low err", {31'd0, err}, 1);
    chk("R6 low match", {20'd0, match_off}, 0);
    poke(12'h100, {12'hFFC, 4'h1, 16'h0001});
    run(1'b0, 16'h0010, 4'h0, 12'h000);
    chk("R6 high err", {31'd0, err}, 1);
    chk("R6 high reads", rd_cnt, 1);

    // R7 self loop hits step limit
    poke(12'h100, {12'h100, 4'h1, 16'h0001});
    run(1'b0, 16'h0022, 4'h0, 12'h000);
    chk("R7 err", {31'd0, err}, 1);
    chk("R7 reads", rd_cnt, 960);
    // the loop header still matches its own id on the first visit
    run(1'b0, 16'h0001, 4'h0, 12'h000);
    chk("R4 loop head hit", {20'd0, match_off}, 32'h100);
    chk("R7 no err on hit", {31'd0, err}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule